// File: doc/BRIEF.md
# Saturating Event and Uptime Log Folder

This block keeps four pending event counters and a running seconds accumulator. It folds both into a small byte image of a persistent log record that it holds on chip. Event sources raise increments of any size against one of the four counters. A one-second tick feeds the accumulator. When the host asks for an update, the block merges the pending counts into the stored 8-bit counters, turns whole hours of accumulated time into a stored 16-bit hour total, and recomputes the record checksum.

Each stage saturates on its own. A pending count stops at 255. A merged counter stops at 0xFF. The hour total stops at 0xFFFF. Seconds left over after the hour transfer stay in the accumulator. After an update the block reports whether any byte changed and the highest changed offset. The host can then copy only that prefix of the image back to non-volatile storage. The host loads and reads the image through a simple byte port while the block is idle.

Top module: `errlog_fold`

## Requirements
- R1: An accepted increment adds `inc_amt` to the pending counter chosen by `inc_sel`, and the pending counter saturates at 255. Selector k merges into the stored byte at offset 4+k.
- R2: While an update runs, `inc_ready` is low. An increment held on the inputs during that time is accepted after the update ends and is not lost.
- R3: An update with all pending counters zero and fewer than 3600 accumulated seconds finishes with `changed`=0, `hwm`=0 and `wb_len`=0, and leaves every image byte unchanged.
- R4: On merge, each non-zero pending count is added to its stored byte, saturating at 0xFF, and the pending count is then cleared. A later update with no new events does nothing.
- R5: The whole hours, seconds/3600, are added to the stored hour total. The low byte is at offset 8 and the high byte at offset 9. The sum saturates at 0xFFFF.
- R6: Only hours×3600 is taken from the accumulator, so the remainder carries forward. A tick that arrives in the same cycle as the transfer is still counted. The accumulator saturates at its all-ones value.
- R7: `changed` is 1 only if some image byte took a new value. `hwm` is the highest offset that changed, and `wb_len` = `hwm`+1. All three are valid when `upd_done` is high.
- R8: When the image changed, the checksum byte at offset 0 is rewritten as the bitwise inverse of (the 8-bit sum of the first L bytes minus the old checksum byte). L is the length byte at offset 1, capped at the record size of 16.
- R9: An update that runs but changes no byte leaves the checksum byte untouched. An example is a pending count merged into a counter already at 0xFF.
- R10: `upd_done` is a one-cycle strobe and comes with `upd_busy` low. A request seen while idle gives either busy or done in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inc_valid | input | 1 | Increment request |
| inc_sel | input | 2 | Pending counter index 0..3 |
| inc_amt | input | 8 | Increment amount |
| inc_ready | output | 1 | Increment accepted this cycle when high with inc_valid |
| sec_tick | input | 1 | One elapsed second |
| secs | output | SEC_W | Seconds accumulator |
| upd_req | input | 1 | Start an update (pulse) |
| upd_busy | output | 1 | Update in progress |
| upd_done | output | 1 | Update finished (one cycle) |
| changed | output | 1 | Image modified by last update |
| hwm | output | AW | Highest changed byte offset, 0 if none |
| wb_len | output | AW+1 | Bytes to write back, 0 if none |
| img_we | input | 1 | Image byte write, honoured when idle |
| img_waddr | input | AW | Image write offset |
| img_wdata | input | 8 | Image write data |
| img_raddr | input | AW | Image read offset |
| img_rdata | output | 8 | Image read data |

## Verification
Two things can land in the same cycle: the hour transfer subtracting whole hours from the accumulator, and a fresh second tick adding to it. The bench holds `sec_tick` high for the whole of an update that moves two hours, and counts every tick it drives. It then requires the accumulator to equal the old remainder plus exactly that many ticks. In the same update it holds an increment on the inputs, requires `inc_ready` to stay low while busy, and checks that the increment shows up in the next merge.

// File: rtl/errlog_fold.sv
module errlog_fold #(
  parameter int REC_BYTES = 16,
  parameter int SEC_W     = 20,
  parameter int HOUR_SECS = 3600,
  parameter int CSUM_OFS  = 0,
  parameter int LEN_OFS   = 1,
  parameter int CNT_OFS   = 4,
  parameter int HRS_OFS   = 8,
  localparam int AW = $clog2(REC_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_valid,
  input  logic [1:0]       inc_sel,
  input  logic [7:0]       inc_amt,
  output logic             inc_ready,
  input  logic             sec_tick,
  output logic [SEC_W-1:0] secs,
  input  logic             upd_req,
  output logic             upd_busy,
  output logic             upd_done,
  output logic             changed,
  output logic [AW-1:0]    hwm,
  output logic [AW:0]      wb_len,
  input  logic             img_we,
  input  logic [AW-1:0]    img_waddr,
  input  logic [7:0]       img_wdata,
  input  logic [AW-1:0]    img_raddr,
  output logic [7:0]       img_rdata
);
  localparam logic [SEC_W-1:0] HSEC = SEC_W'(HOUR_SECS);
  localparam logic [AW:0]      RECN = (AW+1)'(REC_BYTES);
  localparam int               TW   = SEC_W + 17;

  typedef enum logic [2:0] {S_IDLE, S_MERGE, S_HOURS, S_SUM, S_FIN} st_t;
  st_t st;

  logic [7:0]  mem [REC_BYTES];
  logic [7:0]  pend [4];
  logic [AW:0] idx;
  logic [7:0]  sum;

  assign upd_busy  = st != S_IDLE;
  assign inc_ready = !upd_busy && !upd_req;
  assign img_rdata = mem[img_raddr];

  logic [8:0] inc_sum;
  assign inc_sum = {1'b0, pend[inc_sel]} + {1'b0, inc_amt};

  logic [1:0]    k;
  logic [AW-1:0] cnt_a;
  logic [8:0]    mrg_sum;
  logic [7:0]    mrg;
  assign k       = idx[1:0];
  assign cnt_a   = AW'(CNT_OFS) + AW'(k);
  assign mrg_sum = {1'b0, mem[cnt_a]} + {1'b0, pend[k]};
  assign mrg     = mrg_sum[8] ? 8'hFF : mrg_sum[7:0];

  logic [SEC_W-1:0] hrs, sec_up;
  logic [SEC_W:0]   sec_up_w;
  assign hrs      = secs / HSEC;
  assign sec_up_w = {1'b0, secs} + (SEC_W+1)'(sec_tick);
  assign sec_up   = sec_up_w[SEC_W] ? '1 : sec_up_w[SEC_W-1:0];

  logic [TW-1:0] hr_tot;
  logic [15:0]   hr_new;
  assign hr_tot = TW'({mem[HRS_OFS+1], mem[HRS_OFS]}) + TW'(hrs);
  assign hr_new = (hr_tot > TW'(17'h0FFFF)) ? 16'hFFFF : hr_tot[15:0];

  logic [AW:0] n;
  assign n = (32'(mem[LEN_OFS]) > REC_BYTES) ? RECN : (AW+1)'(mem[LEN_OFS]);

  logic noop;
  assign noop = ((pend[0] | pend[1] | pend[2] | pend[3]) == 8'd0) && (secs < HSEC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      secs     <= '0;
      upd_done <= 1'b0;
      changed  <= 1'b0;
      hwm      <= '0;
      wb_len   <= '0;
      idx      <= '0;
      sum      <= '0;
      for (int i = 0; i < 4; i++) pend[i] <= '0;
      for (int i = 0; i < REC_BYTES; i++) mem[i] <= '0;
    end else begin
      upd_done <= 1'b0;
      secs     <= sec_up;
      if (inc_valid && inc_ready)
        pend[inc_sel] <= inc_sum[8] ? 8'hFF : inc_sum[7:0];
      if (!upd_busy && img_we)
        mem[img_waddr] <= img_wdata;
      case (st)
        S_IDLE: if (upd_req) begin
          changed <= 1'b0;
          hwm     <= '0;
          wb_len  <= '0;
          idx     <= '0;
          if (noop) upd_done <= 1'b1;
          else      st       <= S_MERGE;
        end
        S_MERGE: begin
          if (pend[k] != 8'd0) begin
            if (mrg != mem[cnt_a]) begin
              mem[cnt_a] <= mrg;
              changed    <= 1'b1;
              hwm        <= cnt_a;
            end
            pend[k] <= '0;
          end
          idx <= idx + 1'b1;
          if (k == 2'd3) st <= S_HOURS;
        end
        S_HOURS: begin
          secs <= sec_up - hrs * HSEC;
          if (hrs != '0) begin
            if (hr_new[7:0] != mem[HRS_OFS]) begin
              mem[HRS_OFS] <= hr_new[7:0];
              changed      <= 1'b1;
              hwm          <= AW'(HRS_OFS);
            end
            if (hr_new[15:8] != mem[HRS_OFS+1]) begin
              mem[HRS_OFS+1] <= hr_new[15:8];
              changed        <= 1'b1;
              hwm            <= AW'(HRS_OFS + 1);
            end
          end
          idx <= '0;
          sum <= '0;
          st  <= S_SUM;
        end
        S_SUM: begin
          if (!changed || idx == n) st <= S_FIN;
          else begin
            sum <= sum + mem[idx[AW-1:0]];
            idx <= idx + 1'b1;
          end
        end
        S_FIN: begin
          if (changed) begin
            mem[CSUM_OFS] <= ~(sum - mem[CSUM_OFS]);
            wb_len        <= (AW+1)'(hwm) + 1'b1;
          end
          upd_done <= 1'b1;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/errlog_fold_chk.sv
module errlog_fold_chk #(
  parameter int SEC_W = 20,
  parameter int AW    = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inc_ready,
  input logic             upd_req,
  input logic             upd_busy,
  input logic             upd_done,
  input logic             changed,
  input logic [AW-1:0]    hwm,
  input logic [AW:0]      wb_len,
  input logic [SEC_W-1:0] secs
);
  a_r2_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    upd_busy |-> !inc_ready);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> !upd_busy);

  a_r10_req_progress: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && !upd_busy) |=> (upd_busy || upd_done));

  a_r3_quiet_result: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_done && !changed) |-> (hwm == '0 && wb_len == '0));

  a_r6_idle_secs_mono: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_busy |=> secs >= $past(secs));
endmodule

bind errlog_fold errlog_fold_chk #(.SEC_W(SEC_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inc_ready(inc_ready), .upd_req(upd_req),
  .upd_busy(upd_busy), .upd_done(upd_done), .changed(changed),
  .hwm(hwm), .wb_len(wb_len), .secs(secs)
);

// File: tb/errlog_fold_tb.sv
`timescale 1ns/1ps
module errlog_fold_tb;
  localparam int SEC_W = 20;
  localparam int AW    = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic inc_valid = 1'b0, sec_tick = 1'b0, upd_req = 1'b0, img_we = 1'b0;
  logic [1:0] inc_sel = '0;
  logic [7:0] inc_amt = '0, img_wdata = '0, img_rdata;
  logic [AW-1:0] img_waddr = '0, img_raddr = '0, hwm;
  logic [AW:0] wb_len;
  logic [SEC_W-1:0] secs;
  logic inc_ready, upd_busy, upd_done, changed;

  always #2.5 clk = ~clk;

  errlog_fold u_dut (.*);

  int n_cmp = 0, n_bad = 0, done_cnt = 0;
  int m_mem [16];
  int m_pend [4];
  int m_secs = 0;
  int q_chg[$], q_hwm[$], q_len[$];

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && upd_done) begin
      if (q_chg.size() == 0) chk("R10 unexpected done", 1, 0);
      else begin
        chk("R7 changed", int'(changed), q_chg.pop_front());
        chk("R7 hwm", int'(hwm), q_hwm.pop_front());
        chk("R7 wb_len", int'(wb_len), q_len.pop_front());
      end
      done_cnt++;
    end
  end

  task automatic check_img(string req);
    for (int a = 0; a < 16; a++) begin
      img_raddr = AW'(a);
      #1;
      chk(req, int'(img_rdata), m_mem[a]);
    end
  endtask

  task automatic put(int a, int v);
    @(negedge clk);
    img_we = 1'b1; img_waddr = AW'(a); img_wdata = 8'(v);
    @(negedge clk);
    img_we = 1'b0;
    m_mem[a] = v;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sec_tick = 1'b1;
    end
    @(negedge clk);
    sec_tick = 1'b0;
    m_secs += n;
  endtask

  task automatic do_inc(int sel, int amt);
    @(negedge clk);
    inc_valid = 1'b1; inc_sel = 2'(sel); inc_amt = 8'(amt);
    while (!inc_ready) @(negedge clk);
    @(negedge clk);
    inc_valid = 1'b0;
    m_pend[sel] = (m_pend[sel] + amt > 255) ? 255 : m_pend[sel] + amt;
  endtask

  task automatic do_update();
    int chg = 0, hw = 0, d0, h, st, tot, s, n, v;
    if (!(m_pend[0] == 0 && m_pend[1] == 0 && m_pend[2] == 0 && m_pend[3] == 0
          && m_secs < 3600)) begin
      for (int k = 0; k < 4; k++) begin
        if (m_pend[k] != 0) begin
          v = m_mem[4+k] + m_pend[k];
          if (v > 255) v = 255;
          if (v != m_mem[4+k]) begin m_mem[4+k] = v; chg = 1; hw = 4 + k; end
          m_pend[k] = 0;
        end
      end
      h = m_secs / 3600;
      if (h != 0) begin
        st  = m_mem[8] | (m_mem[9] << 8);
        tot = (st + h > 65535) ? 65535 : st + h;
        if ((tot & 255) != m_mem[8]) begin m_mem[8] = tot & 255; chg = 1; hw = 8; end
        if ((tot >> 8) != m_mem[9]) begin m_mem[9] = tot >> 8; chg = 1; hw = 9; end
      end
      m_secs -= h * 3600;
      if (chg) begin
        n = (m_mem[1] > 16) ? 16 : m_mem[1];
        s = 0;
        for (int i = 0; i < n; i++) s += m_mem[i];
        m_mem[0] = (~(s - m_mem[0])) & 255;
      end
    end
    q_chg.push_back(chg);
    q_hwm.push_back(hw);
    q_len.push_back(chg ? hw + 1 : 0);
    d0 = done_cnt;
    @(negedge clk);
    upd_req = 1'b1;
    @(negedge clk);
    upd_req = 1'b0;
    wait (done_cnt != d0);
    @(negedge clk);
    chk("R10 done one cycle", int'(upd_done), 0);
    chk("R10 idle after done", int'(upd_busy), 0);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL R10 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m_mem[i] = 0;
    for (int i = 0; i < 4; i++) m_pend[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset busy", int'(upd_busy), 0);
    chk("R2 reset ready", int'(inc_ready), 1);
    chk("R6 reset secs", int'(secs), 0);
    check_img("R3 reset image");

    put(0, 8'h5A); put(1, 12); put(2, 8'h11); put(3, 8'h22);
    put(4, 10); put(5, 250); put(6, 255); put(7, 0);
    put(8, 8'h34); put(9, 8'h12); put(10, 8'h77); put(13, 8'h99);

    do_update();
    check_img("R3 noop image");

    do_inc(0, 5); do_inc(1, 3); do_inc(1, 4); do_inc(2, 200);
    do_inc(3, 200); do_inc(3, 100);
    do_update();
    check_img("R1 R4 R8 merge image");

    do_update();
    check_img("R4 cleared pending image");

    do_inc(2, 1);
    do_update();
    check_img("R9 untouched checksum");

    ticks(7300);
    do_update();
    check_img("R5 hours image");
    chk("R6 remainder", int'(secs), m_secs);

    put(8, 8'hFF); put(9, 8'h12);
    ticks(3600);
    do_update();
    check_img("R5 R7 high byte image");

    put(8, 8'hFE); put(9, 8'hFF);
    ticks(3 * 3600);
    do_update();
    check_img("R5 hour saturation image");
    chk("R6 remainder after sat", int'(secs), m_secs);

    put(1, 8'hFF);
    do_inc(0, 1);
    do_update();
    check_img("R8 length cap image");

    put(1, 10); put(8, 8'h10); put(9, 0);
    ticks(7200);
    fork
      do_update();
      ticks(30);
      begin
        repeat (2) @(negedge clk);
        chk("R2 ready low while busy", int'(inc_ready), 0);
        do_inc(0, 9);
      end
    join
    check_img("R5 concurrent tick image");
    chk("R6 tick during transfer", int'(secs), m_secs);
    do_update();
    check_img("R2 held increment merged");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule